// File: doc/BRIEF.md
# Tag Check Fault Policy Unit

This unit decides what a failed memory tag comparison does. A checker upstream presents one failure at a time on a valid/ready channel, with the failing virtual address, whether the access was a store, the exception level it belongs to, whether the translation regime is for user code, and whether that regime splits the address space into two ranges. The matching system control register value comes in alongside. A two-bit policy field in that register picks one of four outcomes. The failure can be dropped. It can become a synchronous data abort request. It can set a sticky asynchronous fault flag. In split mode, stores set the flag and loads abort.

A synchronous abort is a request with its own valid/ready pair. It carries a fixed fault status code, the write/not-read bit and the faulting address. It stays up, unchanged, until the exception logic takes it. While it is pending, `fail_ready` is low, so the upstream checker stalls and no failure is lost or merged. An asynchronous outcome ORs one bit into a two-bit flag field kept for each exception level, and gives a one-cycle set pulse. Software can overwrite a level's field through a plain write port. Nothing else clears a flag.

Top module: `tag_fault_policy`

## Requirements
- R1: After reset `abort_valid` and `flag_set_valid` are 0, `flags_out` is all zero and `fail_ready` is 1.
- R2: The policy field is `ctrl_reg[39:38]` when `fail_user` is 1 and `ctrl_reg[41:40]` otherwise; the other field is ignored.
- R3: Policy 0: an accepted failure raises no abort, gives no set pulse and changes no flag.
- R4: Policy 1: an accepted failure makes `abort_valid` 1 on the next cycle, with `abort_fsc` = 6'h11, `abort_wnr` = `fail_write` and `abort_addr` = `fail_addr`.
- R5: Policy 2: an accepted failure sets a flag and raises no abort.
- R6: Policy 3: an accepted store failure (`fail_write`=1) sets a flag and an accepted load failure aborts as in R4.
- R7: The flag bit set is bit `fail_addr[55]` when `fail_two_ranges` is 1 and bit 0 otherwise, within the field of level `fail_el`; level L occupies `flags_out[2L+1:2L]`.
- R8: Flags are sticky. A `sw_wr_en` cycle replaces level `sw_wr_lvl`'s field with `sw_wr_data`, and a flag set on the same edge is ORed on top of the written value.
- R9: A failure is accepted when `fail_valid` and `fail_ready` are both 1, and `fail_ready` equals the inverse of `abort_valid`. An abort holds its fields stable until the cycle in which `abort_ready` is 1, and drops on the next cycle.
- R10: A flag set shows one cycle after acceptance as a single-cycle `flag_set_valid` pulse. `flag_set_lvl` gives the level and `flag_set_bits` is one-hot. The flag is visible in `flags_out` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fail_valid | input | 1 | A tag check failure is offered |
| fail_ready | output | 1 | Unit can take a failure (no abort pending) |
| fail_addr | input | 64 | Failing virtual address |
| fail_write | input | 1 | 1 for a store, 0 for a load |
| fail_el | input | 2 | Exception level whose flag field is targeted |
| fail_user | input | 1 | Regime is a user-level regime |
| fail_two_ranges | input | 1 | Regime has two address ranges |
| ctrl_reg | input | 64 | System control register of the regime |
| abort_valid | output | 1 | Synchronous abort request |
| abort_ready | input | 1 | Exception logic takes the abort |
| abort_fsc | output | 6 | Fault status code (0x11) |
| abort_wnr | output | 1 | Write/not-read bit of the abort |
| abort_addr | output | 64 | Faulting virtual address |
| flag_set_valid | output | 1 | One-cycle pulse: a flag was set |
| flag_set_lvl | output | 2 | Level whose field was set |
| flag_set_bits | output | 2 | One-hot bit that was set |
| sw_wr_en | input | 1 | Software write of a flag field |
| sw_wr_lvl | input | 2 | Level being written |
| sw_wr_data | input | 2 | New field value |
| flags_out | output | 8 | Sticky flag fields, two bits per level |

## Verification
A wrong pending-abort state shows at once: `fail_ready` would no longer be the inverse of `abort_valid`, and the abort fields would change while the request waits. The per-cycle model sees either on the very cycle it happens. A wrong flag state comes out on `flags_out` one cycle after the edge that caused it, because flags are never hidden. A bad policy decode gives the wrong outcome one cycle after acceptance. That outcome is a missing or extra abort, or a pulse at the wrong level or bit. The bench drives each policy under both regime kinds so that a swapped field position shows too.

// File: rtl/tag_fault_policy_pkg.sv
package tag_fault_policy_pkg;

  localparam logic [5:0] TAG_FAULT_FSC = 6'h11;

  typedef enum logic [1:0] {
    POL_OFF   = 2'd0,
    POL_SYNC  = 2'd1,
    POL_ASYNC = 2'd2,
    POL_SPLIT = 2'd3
  } policy_e;

  typedef struct packed {
    logic do_abort;
    logic do_flag;
    logic flag_sel;
  } fault_action_t;

endpackage

// File: rtl/tfp_decode.sv
module tfp_decode
  import tag_fault_policy_pkg::*;
#(
  parameter int CTRL_W   = 64,
  parameter int ADDR_W   = 64,
  parameter int USER_LO  = 38,
  parameter int PRIV_LO  = 40,
  parameter int RANGE_BIT = 55
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              user,
  input  logic              is_write,
  input  logic              two_ranges,
  input  logic [ADDR_W-1:0] addr,
  output fault_action_t     act
);

  policy_e pol;

  always_comb begin
    pol = policy_e'(user ? ctrl[USER_LO +: 2] : ctrl[PRIV_LO +: 2]);
    act.do_abort = 1'b0;
    act.do_flag  = 1'b0;
    unique case (pol)
      POL_OFF:   ;
      POL_SYNC:  act.do_abort = 1'b1;
      POL_ASYNC: act.do_flag  = 1'b1;
      POL_SPLIT: begin
        act.do_flag  = is_write;
        act.do_abort = ~is_write;
      end
      default:   ;
    endcase
    act.flag_sel = two_ranges & addr[RANGE_BIT];
  end

endmodule

// File: rtl/tfp_abort_hold.sv
module tfp_abort_hold
  import tag_fault_policy_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_wnr,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              ack,
  output logic              pend,
  output logic [5:0]        fsc,
  output logic              wnr,
  output logic [ADDR_W-1:0] addr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      wnr  <= 1'b0;
      addr <= '0;
    end else if (load) begin
      pend <= 1'b1;
      wnr  <= load_wnr;
      addr <= load_addr;
    end else if (pend && ack) begin
      pend <= 1'b0;
    end
  end

  assign fsc = pend ? TAG_FAULT_FSC : 6'h00;

endmodule

// File: rtl/tfp_flag_bank.sv
module tfp_flag_bank #(
  parameter int NUM_LVL = 4,
  localparam int LVL_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [LVL_W-1:0]     set_lvl,
  input  logic                 set_sel,
  input  logic                 wr_en,
  input  logic [LVL_W-1:0]     wr_lvl,
  input  logic [1:0]           wr_data,
  output logic [2*NUM_LVL-1:0] flags,
  output logic                 pulse,
  output logic [LVL_W-1:0]     pulse_lvl,
  output logic [1:0]           pulse_bits
);

  logic [1:0] set_mask;
  assign set_mask = set_sel ? 2'b10 : 2'b01;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [1:0] field_q;
    logic [1:0] base;
    logic       hit_wr;
    logic       hit_set;

    assign hit_wr  = wr_en  && (wr_lvl  == LVL_W'(l));
    assign hit_set = set_en && (set_lvl == LVL_W'(l));
    assign base    = hit_wr ? wr_data : field_q;

    always_ff @(posedge clk) begin
      if (!rst_n) field_q <= 2'b00;
      else        field_q <= base | (hit_set ? set_mask : 2'b00);
    end

    assign flags[2*l +: 2] = field_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse      <= 1'b0;
      pulse_lvl  <= '0;
      pulse_bits <= 2'b00;
    end else begin
      pulse      <= set_en;
      pulse_lvl  <= set_en ? set_lvl : '0;
      pulse_bits <= set_en ? set_mask : 2'b00;
    end
  end

endmodule

// File: rtl/tag_fault_policy.sv
module tag_fault_policy
  import tag_fault_policy_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int CTRL_W    = 64,
  parameter int NUM_LVL   = 4,
  parameter int USER_LO   = 38,
  parameter int PRIV_LO   = 40,
  parameter int RANGE_BIT = 55,
  localparam int LVL_W    = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fail_valid,
  output logic                 fail_ready,
  input  logic [ADDR_W-1:0]    fail_addr,
  input  logic                 fail_write,
  input  logic [LVL_W-1:0]     fail_el,
  input  logic                 fail_user,
  input  logic                 fail_two_ranges,
  input  logic [CTRL_W-1:0]    ctrl_reg,
  output logic                 abort_valid,
  input  logic                 abort_ready,
  output logic [5:0]           abort_fsc,
  output logic                 abort_wnr,
  output logic [ADDR_W-1:0]    abort_addr,
  output logic                 flag_set_valid,
  output logic [LVL_W-1:0]     flag_set_lvl,
  output logic [1:0]           flag_set_bits,
  input  logic                 sw_wr_en,
  input  logic [LVL_W-1:0]     sw_wr_lvl,
  input  logic [1:0]           sw_wr_data,
  output logic [2*NUM_LVL-1:0] flags_out
);

  fault_action_t act;
  logic          accept;
  logic          pend;

  assign fail_ready = ~pend;
  assign accept     = fail_valid & ~pend;

  tfp_decode #(
    .CTRL_W(CTRL_W), .ADDR_W(ADDR_W), .USER_LO(USER_LO),
    .PRIV_LO(PRIV_LO), .RANGE_BIT(RANGE_BIT)
  ) u_decode (
    .ctrl(ctrl_reg), .user(fail_user), .is_write(fail_write),
    .two_ranges(fail_two_ranges), .addr(fail_addr), .act(act)
  );

  tfp_abort_hold #(.ADDR_W(ADDR_W)) u_abort (
    .clk(clk), .rst_n(rst_n),
    .load(accept & act.do_abort), .load_wnr(fail_write), .load_addr(fail_addr),
    .ack(abort_ready),
    .pend(pend), .fsc(abort_fsc), .wnr(abort_wnr), .addr(abort_addr)
  );

  assign abort_valid = pend;

  tfp_flag_bank #(.NUM_LVL(NUM_LVL)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_en(accept & act.do_flag), .set_lvl(fail_el), .set_sel(act.flag_sel),
    .wr_en(sw_wr_en), .wr_lvl(sw_wr_lvl), .wr_data(sw_wr_data),
    .flags(flags_out),
    .pulse(flag_set_valid), .pulse_lvl(flag_set_lvl), .pulse_bits(flag_set_bits)
  );

endmodule

// File: rtl/tag_fault_policy_chk.sv
module tag_fault_policy_chk #(
  parameter int ADDR_W  = 64,
  parameter int NUM_LVL = 4,
  parameter int LVL_W   = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fail_ready,
  input logic                 abort_valid,
  input logic                 abort_ready,
  input logic [5:0]           abort_fsc,
  input logic                 abort_wnr,
  input logic [ADDR_W-1:0]    abort_addr,
  input logic                 flag_set_valid,
  input logic [LVL_W-1:0]     flag_set_lvl,
  input logic [1:0]           flag_set_bits,
  input logic                 sw_wr_en,
  input logic [2*NUM_LVL-1:0] flags_out
);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    abort_valid && !abort_ready |=> abort_valid && $stable(abort_addr) && $stable(abort_wnr));

  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    abort_valid |-> !fail_ready);

  a_r4_fsc: assert property (@(posedge clk) disable iff (!rst_n)
    abort_valid |-> abort_fsc == 6'h11);

  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set_valid |-> $countones(flag_set_bits) == 1);

  a_r10_visible: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set_valid |-> (flags_out[flag_set_lvl*2 +: 2] & flag_set_bits) == flag_set_bits);

  a_r5_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set_valid |-> !$rose(abort_valid));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_en |=> (flags_out & $past(flags_out)) == $past(flags_out));

endmodule

bind tag_fault_policy tag_fault_policy_chk #(
  .ADDR_W(ADDR_W), .NUM_LVL(NUM_LVL), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fail_ready(fail_ready),
  .abort_valid(abort_valid), .abort_ready(abort_ready), .abort_fsc(abort_fsc),
  .abort_wnr(abort_wnr), .abort_addr(abort_addr),
  .flag_set_valid(flag_set_valid), .flag_set_lvl(flag_set_lvl),
  .flag_set_bits(flag_set_bits), .sw_wr_en(sw_wr_en), .flags_out(flags_out)
);

// File: tb/tag_fault_policy_test.sv
module tag_fault_policy_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fail_valid = 1'b0;
  logic        fail_ready;
  logic [63:0] fail_addr = '0;
  logic        fail_write = 1'b0;
  logic [1:0]  fail_el = '0;
  logic        fail_user = 1'b0;
  logic        fail_two_ranges = 1'b0;
  logic [63:0] ctrl_reg = '0;
  logic        abort_valid;
  logic        abort_ready = 1'b0;
  logic [5:0]  abort_fsc;
  logic        abort_wnr;
  logic [63:0] abort_addr;
  logic        flag_set_valid;
  logic [1:0]  flag_set_lvl;
  logic [1:0]  flag_set_bits;
  logic        sw_wr_en = 1'b0;
  logic [1:0]  sw_wr_lvl = '0;
  logic [1:0]  sw_wr_data = '0;
  logic [7:0]  flags_out;

  always #2 clk = ~clk;

  tag_fault_policy uut (.*);

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string tag = "R1";

  // Behavioural reference model
  bit        m_abort;
  bit        m_wnr;
  bit [63:0] m_addr;
  bit [1:0]  m_flags [4];
  bit        m_set;
  int        m_set_lvl;
  bit [1:0]  m_set_bits;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_abort = 0; m_wnr = 0; m_addr = 0; m_set = 0; m_set_lvl = 0; m_set_bits = 0;
      foreach (m_flags[i]) m_flags[i] = 0;
    end else begin
      bit take;
      int pol;
      bit sync_o, async_o;
      take = fail_valid && !m_abort;
      if (m_abort && abort_ready) m_abort = 0;
      if (sw_wr_en) m_flags[sw_wr_lvl] = sw_wr_data;
      m_set = 0; m_set_lvl = 0; m_set_bits = 0;
      if (take) begin
        pol = fail_user ? int'(ctrl_reg[39:38]) : int'(ctrl_reg[41:40]);
        sync_o  = (pol == 1) || (pol == 3 && !fail_write);
        async_o = (pol == 2) || (pol == 3 && fail_write);
        if (sync_o) begin m_abort = 1; m_wnr = fail_write; m_addr = fail_addr; end
        if (async_o) begin
          m_set = 1; m_set_lvl = fail_el;
          m_set_bits = (fail_two_ranges && fail_addr[55]) ? 2'b10 : 2'b01;
          m_flags[fail_el] = m_flags[fail_el] | m_set_bits;
        end
      end
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // compared every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit [7:0] ef;
      for (int i = 0; i < 4; i++) ef[2*i +: 2] = m_flags[i];
      chk("R9", "fail_ready", fail_ready, !m_abort);
      chk({tag, "/R4"}, "abort_valid", abort_valid, m_abort);
      if (m_abort) begin
        chk("R4", "abort_fsc", abort_fsc, 6'h11);
        chk("R4", "abort_wnr", abort_wnr, m_wnr);
        chk("R4", "abort_addr", abort_addr, m_addr);
      end
      chk({tag, "/R10"}, "flag_set_valid", flag_set_valid, m_set);
      if (m_set) begin
        chk("R10", "flag_set_lvl", flag_set_lvl, m_set_lvl);
        chk("R7", "flag_set_bits", flag_set_bits, m_set_bits);
      end
      chk({tag, "/R8"}, "flags_out", flags_out, ef);
    end
  end

  function automatic logic [63:0] ctl(int pol, bit user);
    logic [63:0] c;
    c = 64'h0;
    if (user) begin c[39:38] = pol[1:0]; c[41:40] = ~pol[1:0]; end
    else      begin c[41:40] = pol[1:0]; c[39:38] = ~pol[1:0]; end
    return c;
  endfunction

  task automatic fail1(int pol, bit user, bit wr, int el, bit two, logic [63:0] a);
    @(negedge clk);
    fail_valid = 1; fail_write = wr; fail_el = el[1:0]; fail_user = user;
    fail_two_ranges = two; fail_addr = a; ctrl_reg = ctl(pol, user);
    @(negedge clk);
    fail_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : wd
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1";
    chk("R1", "reset abort_valid", abort_valid, 0);
    chk("R1", "reset flags", flags_out, 0);
    chk("R1", "reset fail_ready", fail_ready, 1);

    tag = "R3"; fail1(0, 0, 1, 1, 1, 64'h0080_0000_0000_1000); idle(2);
    chk("R3", "no flag after off policy", flags_out, 0);

    tag = "R4"; abort_ready = 0;
    fail1(1, 0, 1, 2, 0, 64'h1234_5678_9abc_def0);
    chk("R4", "abort up", abort_valid, 1);
    chk("R9", "stall while pending", fail_ready, 0);
    fail_valid = 1; idle(3); fail_valid = 0;      // offered but not taken
    abort_ready = 1; idle(1); abort_ready = 0; idle(1);
    chk("R9", "abort dropped after ack", abort_valid, 0);

    tag = "R5"; fail1(2, 0, 0, 2, 1, 64'h0080_0000_0000_0040); idle(1);
    chk("R5", "async flag lvl2 bit1", flags_out[5:4], 2'b10);
    chk("R5", "no abort", abort_valid, 0);

    tag = "R7"; fail1(2, 0, 0, 3, 0, 64'h0080_0000_0000_0040); idle(1);
    chk("R7", "single range uses bit0", flags_out[7:6], 2'b01);

    tag = "R6"; fail1(3, 0, 1, 1, 0, 64'h40); idle(1);
    chk("R6", "split store flags", flags_out[3:2], 2'b01);
    abort_ready = 1; fail1(3, 0, 0, 1, 0, 64'h80);
    chk("R6", "split load aborts", abort_valid, 1);
    idle(2); abort_ready = 0;

    tag = "R2"; fail1(2, 1, 0, 0, 0, 64'h0); idle(1);
    chk("R2", "user field used", flags_out[1:0], 2'b01);
    abort_ready = 1; fail1(1, 1, 0, 0, 0, 64'hff0); idle(2); abort_ready = 0;

    tag = "R8";
    sw_wr_en = 1; sw_wr_lvl = 2; sw_wr_data = 0; idle(1); sw_wr_en = 0; idle(1);
    chk("R8", "software clear", flags_out[5:4], 2'b00);
    @(negedge clk);
    fail_valid = 1; fail_el = 3; fail_user = 0; fail_two_ranges = 1;
    fail_addr = 64'h0080_0000_0000_0000; ctrl_reg = ctl(2, 0); fail_write = 0;
    sw_wr_en = 1; sw_wr_lvl = 3; sw_wr_data = 2'b00;
    @(negedge clk); fail_valid = 0; sw_wr_en = 0;
    chk("R8", "set ORed over write", flags_out[7:6], 2'b10);

    tag = "R10";
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      fail_valid = $urandom_range(0, 1);
      fail_addr = {$urandom, $urandom};
      fail_write = $urandom_range(0, 1);
      fail_el = 2'($urandom_range(0, 3));
      fail_user = $urandom_range(0, 1);
      fail_two_ranges = $urandom_range(0, 1);
      ctrl_reg = {$urandom, $urandom};
      abort_ready = ($urandom_range(0, 3) == 0);
      sw_wr_en = ($urandom_range(0, 15) == 0);
      sw_wr_lvl = 2'($urandom_range(0, 3));
      sw_wr_data = 2'($urandom_range(0, 3));
    end
    @(negedge clk);
    fail_valid = 0; sw_wr_en = 0; abort_ready = 1;
    idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule